// File: doc/BRIEF.md
# Comma-Based Word Aligner

This block sits behind a deserializer and recovers the character boundary of a 10-bit coded serial stream. Bits arrive one at a time, each qualified by a bit enable, first received bit first. The aligner keeps a short window of recent bits and watches for the positive-disparity comma. When a comma appears at the wrong place relative to the current boundary, it moves the boundary in a single cycle so that the comma starts at bit 0 of an output character. It also asks the downstream byte clock generator to stretch its clock.

Output characters alternate between even and odd slots, matching a pair of byte clocks in antiphase. The aligner forces every character that carries a comma into the even slot. The comma-detect flag is updated only when an even character is emitted. An enable input decides whether realignment may happen. While it is low, the boundary stays frozen, but a comma that already lands correctly in an even slot is still flagged.

Top module: `comma_word_aligner`

## Requirements
- R1: The first received bit of a character appears on `char_q[0]` and the tenth on `char_q[9]`. A character is registered, with a one-cycle `char_stb`, in the cycle that consumes its tenth bit.
- R2: The comma is the received bit sequence 0,0,1,1,1,1,1. In an aligned character this is `char_q[6:0] == 7'b1111100`.
- R3: With `align_en` high, a comma that does not start at the current character bit 0 moves the boundary. In the cycle that consumes the comma's seventh bit, `stretch_req` pulses, the partly built character is dropped (no `char_stb`), and the comma character is emitted three bits later with the comma at bits 0 to 6.
- R4: With `align_en` low, the boundary and the slot order never change and `stretch_req` stays low. Characters keep being cut every ten bits counted from reset.
- R5: After reset `char_q` is zero, `char_stb`, `char_even`, `comma_det` and `stretch_req` are low, and the first character emitted is even.
- R6: Emitted characters alternate between even (`char_even`=1) and odd. With `align_en` high, a comma that is bit-aligned but would fall in an odd slot also triggers a realignment (`stretch_req` pulse), so that its character is emitted as even.
- R7: `comma_det` changes only together with an even character strobe. It is set when that character holds the comma at bits 0 to 6, cleared when it does not, and held across odd characters.
- R8: With `align_en` low, a comma that arrives bit-aligned in an even slot still sets `comma_det`. One that arrives in an odd slot does not.
- R9: A cycle with `bit_en` low changes no state. It emits no character and no stretch request, and `char_q` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Qualifies `bit_in` as one received bit |
| bit_in | input | 1 | Serial data bit |
| align_en | input | 1 | Allows boundary realignment on commas |
| char_q | output | 10 | Last emitted character, bit 0 received first |
| char_stb | output | 1 | One-cycle pulse when `char_q` is updated |
| char_even | output | 1 | Slot of the last emitted character (1 = even) |
| comma_det | output | 1 | Even character held a valid comma |
| stretch_req | output | 1 | One-cycle request to stretch the byte clock |

## Verification
The stream is built from a comma character and a data character that contains no comma across any joint. Several variants are driven through it. A stream shifted by a few leading bits with alignment enabled shows whether the boundary moves once and whether the comma then stays in the even slot. The same shift with alignment disabled shows that the grouping from reset is kept and no flag appears. Aligned streams that put the comma in an even or an odd slot separate the slot realignment from plain bit realignment, with the enable both high and low. Trailing data characters and idle bit-enable gaps check that the flag clears and that idle cycles are ignored.

// File: rtl/aln_pkg.sv
package aln_pkg;
    localparam int CHAR_W  = 10;
    localparam int WIN_W   = 16;
    localparam int COMMA_W = 7;
    // bit i is the i-th received bit of the comma
    localparam logic [COMMA_W-1:0] COMMA_PAT = 7'b1111100;
endpackage

// File: rtl/aln_window.sv
module aln_window #(
    parameter int WIN_W = aln_pkg::WIN_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             bit_in,
    output logic [WIN_W-1:0] win_next
);
    logic [WIN_W-1:0] win_d, win_q;

    // newest bit enters at the top, oldest sits at bit 0
    always_comb begin
        win_next = {bit_in, win_q[WIN_W-1:1]};
        win_d    = bit_en ? win_next : win_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) win_q <= '0;
        else        win_q <= win_d;
    end
endmodule

// File: rtl/aln_comma_scan.sv
module aln_comma_scan #(
    parameter int W   = aln_pkg::WIN_W,
    parameter int OFF = 0
) (
    input  logic [W-1:0] data,
    output logic         hit
);
    import aln_pkg::*;
    logic [COMMA_W-1:0] match;

    for (genvar i = 0; i < COMMA_W; i++) begin : g_cmp
        assign match[i] = (data[OFF+i] == COMMA_PAT[i]);
    end

    assign hit = &match;
endmodule

// File: rtl/aln_frame.sv
module aln_frame #(
    parameter int CHAR_W  = aln_pkg::CHAR_W,
    parameter int WIN_W   = aln_pkg::WIN_W,
    parameter int COMMA_W = aln_pkg::COMMA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              align_en,
    input  logic              comma_end,
    input  logic [WIN_W-1:0]  win_next,
    output logic [CHAR_W-1:0] char_q,
    output logic              char_stb,
    output logic              char_even,
    output logic              comma_det,
    output logic              stretch_req
);
    localparam int CNT_W = $clog2(CHAR_W);
    localparam logic [CNT_W-1:0] LAST_POS  = CNT_W'(CHAR_W - 1);
    localparam logic [CNT_W-1:0] COMMA_END = CNT_W'(COMMA_W - 1);
    localparam logic [CNT_W-1:0] AFTER_END = CNT_W'(COMMA_W);

    typedef struct packed {
        logic [CNT_W-1:0]  pos;     // position of the next incoming bit
        logic              odd;     // slot of the next character (1 = odd)
        logic [CHAR_W-1:0] chr;
        logic              stb;
        logic              even;
        logic              det;
        logic              stretch;
    } frame_t;

    frame_t st_d, st_q;
    logic [CHAR_W-1:0] new_char;
    logic              char_has_comma;
    logic              misplaced;
    logic              realign;
    logic              emit;

    assign new_char = win_next[WIN_W-1 -: CHAR_W];

    aln_comma_scan #(.W(CHAR_W), .OFF(0)) u_char_scan (
        .data (new_char),
        .hit  (char_has_comma)
    );

    always_comb begin
        st_d         = st_q;
        st_d.stb     = 1'b0;
        st_d.stretch = 1'b0;
        misplaced    = (st_q.pos != COMMA_END) || st_q.odd;
        realign      = bit_en && comma_end && align_en && misplaced;
        emit         = bit_en && !realign && (st_q.pos == LAST_POS);
        if (realign) begin
            st_d.pos     = AFTER_END;
            st_d.odd     = 1'b0;
            st_d.stretch = 1'b1;
        end else if (bit_en) begin
            st_d.pos = (st_q.pos == LAST_POS) ? '0 : st_q.pos + 1'b1;
        end
        if (emit) begin
            st_d.chr  = new_char;
            st_d.stb  = 1'b1;
            st_d.even = !st_q.odd;
            st_d.odd  = !st_q.odd;
            if (!st_q.odd) st_d.det = char_has_comma;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign char_q      = st_q.chr;
    assign char_stb    = st_q.stb;
    assign char_even   = st_q.even;
    assign comma_det   = st_q.det;
    assign stretch_req = st_q.stretch;

    a_r1_pos_range: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pos <= LAST_POS);
    a_r3_stretch_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        stretch_req |-> ($past(align_en) && $past(bit_en)));
    a_r3_no_emit_on_stretch: assert property (@(posedge clk) disable iff (!rst_n)
        stretch_req |-> !char_stb);
    a_r7_det_moves_on_even: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(comma_det) |-> (char_stb && char_even));
    a_r2_comma_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        (char_stb && char_even && char_q[COMMA_W-1:0] == aln_pkg::COMMA_PAT) |-> comma_det);
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> (!char_stb && !stretch_req && $stable(char_q)));
endmodule

// File: rtl/comma_word_aligner.sv
module comma_word_aligner #(
    parameter int CHAR_W  = aln_pkg::CHAR_W,
    parameter int WIN_W   = aln_pkg::WIN_W,
    parameter int COMMA_W = aln_pkg::COMMA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              bit_in,
    input  logic              align_en,
    output logic [CHAR_W-1:0] char_q,
    output logic              char_stb,
    output logic              char_even,
    output logic              comma_det,
    output logic              stretch_req
);
    logic [WIN_W-1:0] win_next;
    logic             comma_end;

    aln_window #(.WIN_W(WIN_W)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .bit_in   (bit_in),
        .win_next (win_next)
    );

    // comma whose last bit is the bit arriving now
    aln_comma_scan #(.W(WIN_W), .OFF(WIN_W - COMMA_W)) u_tail_scan (
        .data (win_next),
        .hit  (comma_end)
    );

    aln_frame #(.CHAR_W(CHAR_W), .WIN_W(WIN_W), .COMMA_W(COMMA_W)) u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_en      (bit_en),
        .align_en    (align_en),
        .comma_end   (comma_end),
        .win_next    (win_next),
        .char_q      (char_q),
        .char_stb    (char_stb),
        .char_even   (char_even),
        .comma_det   (comma_det),
        .stretch_req (stretch_req)
    );
endmodule

// File: tb/sim_comma_word_aligner.sv
module sim_comma_word_aligner;
    localparam logic [9:0] KC = 10'b0101111100; // comma character
    localparam logic [9:0] KD = 10'b0010111001; // data character

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_en = 1'b0;
    logic bit_in = 1'b0;
    logic align_en = 1'b0;
    logic [9:0] char_q;
    logic char_stb, char_even, comma_det, stretch_req;

    int n_chk = 0;
    int n_bad = 0;
    logic [9:0] em_c [0:31];
    logic       em_e [0:31];
    logic       em_d [0:31];
    int n_em, n_st, st_at;
    logic [63:0] sent;
    int n_sent;

    always #10 clk = ~clk;

    comma_word_aligner u0 (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
        .align_en(align_en), .char_q(char_q), .char_stb(char_stb),
        .char_even(char_even), .comma_det(comma_det), .stretch_req(stretch_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic en);
        @(negedge clk);
        rst_n = 1'b0; bit_en = 1'b0; align_en = en;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        n_em = 0; n_st = 0; st_at = -1; n_sent = 0; sent = '0;
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        bit_en = 1'b1; bit_in = b;
        if (n_sent < 64) sent[n_sent] = b;
        n_sent++;
        @(posedge clk); #2;
        if (char_stb && n_em < 32) begin
            em_c[n_em] = char_q; em_e[n_em] = char_even; em_d[n_em] = comma_det;
            n_em++;
        end
        if (stretch_req) begin n_st++; st_at = n_em; end
    endtask

    task automatic send_char(input logic [9:0] c);
        for (int i = 0; i < 10; i++) send_bit(c[i]);
    endtask

    task automatic t_reset;
        do_reset(1'b1);
        #2;
        chk("R5 char_q", 32'(char_q), 0);
        chk("R5 flags", {28'd0, char_stb, char_even, comma_det, stretch_req}, 0);
    endtask

    task automatic t_shift_align;
        do_reset(1'b1);
        send_bit(1); send_bit(0); send_bit(1);
        for (int k = 0; k < 3; k++) begin send_char(KC); send_char(KD); end
        chk("R3 one stretch", 32'(n_st), 1);
        chk("R3 stretch before first char", 32'(st_at), 0);
        chk("R3 chars after realign", 32'(n_em), 6);
        for (int k = 0; k < 6; k++) begin
            chk("R1 char value", 32'(em_c[k]), 32'((k % 2 == 0) ? KC : KD));
            chk("R6 slot", 32'(em_e[k]), 32'(k % 2 == 0));
            chk("R7 det held", 32'(em_d[k]), 1);
        end
        send_char(KD); send_char(KD);
        chk("R7 det cleared on even", 32'(em_d[6]), 0);
        chk("R7 even slot", 32'(em_e[6]), 1);
    endtask

    task automatic t_shift_frozen;
        do_reset(1'b0);
        send_bit(1); send_bit(0); send_bit(1); send_bit(0);
        send_char(KC); send_char(KD); send_char(KC); send_char(KD);
        chk("R4 no stretch", 32'(n_st), 0);
        chk("R4 char count", 32'(n_em), 4);
        for (int k = 0; k < 4; k++) begin
            chk("R4 grouping kept", 32'(em_c[k]), 32'(sent[10*k +: 10]));
            chk("R8 no det misaligned", 32'(em_d[k]), 0);
        end
    endtask

    task automatic t_aligned_frozen;
        do_reset(1'b0);
        send_char(KC); send_char(KD);
        chk("R8 det with enable low", 32'(em_d[0]), 1);
        chk("R2 comma char", 32'(em_c[0]), 32'(KC));
        chk("R8 no stretch", 32'(n_st), 0);
    endtask

    task automatic t_odd_slot;
        do_reset(1'b1);
        send_char(KD); send_char(KC); send_char(KD);
        chk("R6 slot stretch", 32'(n_st), 1);
        chk("R6 stretch after one char", 32'(st_at), 1);
        chk("R6 comma forced even", {30'd0, em_e[1], em_d[1]}, 3);
        chk("R6 comma char", 32'(em_c[1]), 32'(KC));
        chk("R6 next odd", 32'(em_e[2]), 0);
        do_reset(1'b0);
        send_char(KD); send_char(KC); send_char(KD); send_char(KC);
        chk("R8 odd comma no det", {28'd0, em_d[0], em_d[1], em_d[2], em_d[3]}, 0);
        chk("R8 odd comma no stretch", 32'(n_st), 0);
        chk("R4 odd slot kept", 32'(em_e[1]), 0);
    endtask

    task automatic t_idle;
        logic [9:0] held;
        int bad;
        do_reset(1'b1);
        send_char(KC);
        send_bit(1); send_bit(0);
        held = char_q; bad = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk); bit_en = 1'b0; bit_in = i[0];
            @(posedge clk); #2;
            if (char_stb || stretch_req || char_q !== held) bad++;
        end
        chk("R9 idle no change", 32'(bad), 0);
        for (int i = 2; i < 10; i++) send_bit(KD[i]);
        chk("R9 char after gap", 32'(em_c[1]), 32'(KD));
        chk("R9 count", 32'(n_em), 2);
    endtask

    initial begin
        t_reset();
        t_shift_align();
        t_shift_frozen();
        t_aligned_frozen();
        t_odd_slot();
        t_idle();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule